// File: doc/BRIEF.md
# LUT Input Stuck-At Fault Injector

This block takes the truth table of a small look-up table (four inputs and sixteen entries by default) and rewrites it so that the table acts as if one of its inputs were tied to a constant. The caller gives the original table, the index of the input to fault, the constant value, and a one-cycle start strobe. The block then walks through the table one entry pair per cycle. In each pair it copies the entry that a stuck input would still reach over the entry that the fault makes unreachable.

The faulted input index sets the distance between the two entries of a pair: input p pairs entry a with entry a + 2^p. The stuck value sets the direction of the copy. When the last pair has been written, a one-cycle done pulse marks that the output table is final. The table is then held until the next accepted start. This gives a fault-injection or repair loop a faulted variant of a table without recomputing the table in software.

The start and done pins are plain control and status pins. There is no valid/ready stream and no back-pressure. The result stays on the output until a new job is accepted, so the consumer may sample it at any time after done.

Top module: `lut_stuck_injector`

## Requirements
- R1: After reset the output table is all zeros and done is low.
- R2: A start strobe sampled while the block is idle captures the input table, the input index and the stuck value. The output table shows the captured table in the next cycle, and the first pair is written at the following clock edge.
- R3: For input index p the two entries of each pair have addresses that differ only in bit p, so the copy stride is 1, 2, 4 or 8 for p = 0, 1, 2, 3. No entry outside the pair changes, and the source entry keeps its value.
- R4: With stuck value 0, the entry whose address has bit p = 0 is copied into the entry whose address has bit p = 1.
- R5: With stuck value 1, the entry whose address has bit p = 1 is copied into the entry whose address has bit p = 0.
- R6: Exactly 2^(N-1) pairs (8 by default) are written, one per clock edge. They are visited in ascending order of the address with bit p removed.
- R7: Done is high for exactly one cycle, namely the cycle that follows the clock edge on which the last pair is written.
- R8: A start strobe sampled while a job is running is ignored and does not change that job's result. A start sampled in the cycle in which done is high is accepted.
- R9: The final table gives the same value for both settings of input p at every address. For every address a, it equals the original table read at a with bit p forced to the stuck value.
- R10: While idle with no start, the output table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a job |
| tbl_in | input | 16 | Original truth table, bit a is the entry at address a |
| pin_sel | input | 2 | Index of the input to fault |
| stuck_val | input | 1 | Constant value of the faulted input |
| tbl_out | output | 16 | Working table, final when done pulses |
| done | output | 1 | One-cycle pulse when the last pair has been written |

## Verification
The bench builds the block with its default of four inputs, which gives sixteen entries and eight pairs per job. This keeps every combination of input index and stuck value within reach of an exhaustive sweep over several tables. A behavioural model tracks the working table on every clock, so the order of the pairs and each intermediate table are compared, not only the final result. Hand-worked tables pin down the stride and the copy direction. A start strobe injected mid-job and one injected in the done cycle exercise the acceptance rule.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lsf_state_e;
endpackage

// File: rtl/lsf_pair_seq.sv
module lsf_pair_seq #(
  parameter int IN_W = 4,
  localparam int SEL_W = (IN_W > 1) ? $clog2(IN_W) : 1,
  localparam int CNT_W = (IN_W > 1) ? IN_W - 1 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [SEL_W-1:0] pin,
  input  logic             val,
  output logic [IN_W-1:0]  src_idx,
  output logic [IN_W-1:0]  dst_idx,
  output logic             last
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [IN_W-1:0]  ONE     = {{(IN_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [IN_W-1:0]  cnt_w, pin_bit, low_mask, low_addr, high_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  // Insert a zero at bit 'pin' of the pair index to form the low address.
  always_comb begin
    cnt_w     = {1'b0, cnt};
    pin_bit   = ONE << pin;
    low_mask  = pin_bit - ONE;
    low_addr  = ((cnt_w >> pin) << ({1'b0, pin} + 1'b1)) | (cnt_w & low_mask);
    high_addr = low_addr | pin_bit;
    src_idx   = val ? high_addr : low_addr;
    dst_idx   = val ? low_addr  : high_addr;
    last      = (cnt == CNT_MAX);
  end

  AST_PAIR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !clear) |=> (cnt == $past(cnt) + 1'b1)); // R6
  AST_PAIR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((src_idx ^ dst_idx) == (ONE << pin))); // R3
  AST_SRC_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (src_idx[pin] == val)); // R4
  AST_DST_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (dst_idx[pin] == !val)); // R5
endmodule

// File: rtl/lsf_table_reg.sv
module lsf_table_reg #(
  parameter int IN_W = 4,
  localparam int ENTRIES = 1 << IN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ENTRIES-1:0] load_data,
  input  logic               wr_en,
  input  logic [IN_W-1:0]    src_idx,
  input  logic [IN_W-1:0]    dst_idx,
  output logic [ENTRIES-1:0] q
);
  logic src_bit;
  assign src_bit = q[src_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [IN_W-1:0] MY_IDX = IN_W'(e);
    always_ff @(posedge clk) begin
      if (!rst_n)                             q[e] <= 1'b0;
      else if (load)                          q[e] <= load_data[e];
      else if (wr_en && (dst_idx == MY_IDX))  q[e] <= src_bit;
    end
  end

  AST_COPY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> (q[$past(dst_idx)] == $past(q[src_idx]))); // R4
  AST_SOURCE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> (q[$past(src_idx)] == $past(q[src_idx]))); // R3
endmodule

// File: rtl/lut_stuck_injector.sv
module lut_stuck_injector #(
  parameter int IN_W = 4,
  localparam int ENTRIES = 1 << IN_W,
  localparam int SEL_W = (IN_W > 1) ? $clog2(IN_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ENTRIES-1:0] tbl_in,
  input  logic [SEL_W-1:0]   pin_sel,
  input  logic               stuck_val,
  output logic [ENTRIES-1:0] tbl_out,
  output logic               done
);
  import lsf_pkg::*;

  localparam logic [IN_W-1:0] ONE = {{(IN_W-1){1'b0}}, 1'b1};

  lsf_state_e       state;
  logic             busy, accept, last;
  logic [SEL_W-1:0] pin_q;
  logic             val_q;
  logic [IN_W-1:0]  src_idx, dst_idx;

  assign busy   = (state == ST_RUN);
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      pin_q <= '0;
      val_q <= 1'b0;
    end else begin
      done <= busy && last;
      if (accept) begin
        state <= ST_RUN;
        pin_q <= pin_sel;
        val_q <= stuck_val;
      end else if (busy && last) begin
        state <= ST_IDLE;
      end
    end
  end

  lsf_pair_seq #(.IN_W(IN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .step    (busy),
    .pin     (pin_q),
    .val     (val_q),
    .src_idx (src_idx),
    .dst_idx (dst_idx),
    .last    (last)
  );

  lsf_table_reg #(.IN_W(IN_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tbl_in),
    .wr_en     (busy),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .q         (tbl_out)
  );

  // Symmetry of the working table across the faulted input.
  logic sym_ok;
  always_comb begin
    sym_ok = 1'b1;
    for (int a = 0; a < ENTRIES; a++) begin
      if (tbl_out[a] != tbl_out[IN_W'(a) ^ (ONE << pin_q)]) sym_ok = 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(pin_q) && $stable(val_q))); // R8
  AST_TABLE_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sym_ok); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(tbl_out)); // R10
endmodule

// File: tb/lut_stuck_injector_tb.sv
module lut_stuck_injector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tbl_in = '0;
  logic [1:0]  pin_sel = '0;
  logic        stuck_val = 1'b0;
  logic [15:0] tbl_out;
  logic        done;

  int vectors = 0;
  int fails = 0;
  bit summary_done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lut_stuck_injector u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_in(tbl_in),
    .pin_sel(pin_sel), .stuck_val(stuck_val), .tbl_out(tbl_out), .done(done)
  );

  // Behavioural reference model
  bit        m_busy = 0;
  bit        m_done = 0;
  int        m_k = 0;
  int        m_pin = 0;
  int        m_val = 0;
  bit [15:0] m_tbl = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_k = 0; m_tbl = '0;
    end else if (m_busy) begin
      int lo, hi, s, d;
      lo = ((m_k >> m_pin) << (m_pin + 1)) + (m_k % (1 << m_pin));
      hi = lo + (1 << m_pin);
      s = m_val ? hi : lo;
      d = m_val ? lo : hi;
      m_tbl[d] = m_tbl[s];
      if (m_k == 7) begin m_busy = 0; m_done = 1; end
      else begin m_k++; m_done = 0; end
    end else begin
      m_done = 0;
      if (start) begin
        m_busy = 1; m_k = 0; m_tbl = tbl_in; m_pin = pin_sel; m_val = stuck_val;
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every-clock comparison against the model (R6 table, R7 done)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 per-cycle table", tbl_out, m_tbl);
      check("R7 per-cycle done", {15'b0, done}, {15'b0, m_done});
    end
  end

  function automatic bit [15:0] forced(bit [15:0] t, int p, int v);
    bit [15:0] r;
    for (int a = 0; a < 16; a++) r[a] = t[(a & ~(1 << p)) | (v << p)];
    return r;
  endfunction

  // Runs a job; returns number of negedges until done seen.
  task automatic run_job(bit [15:0] t, int p, int v, output int cyc);
    @(negedge clk);
    tbl_in = t; pin_sel = 2'(p); stuck_val = v[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 captured table", tbl_out, t);
    cyc = 1;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #2000000;
    if (!summary_done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    bit [15:0] t, held;
    repeat (3) @(negedge clk);
    check("R1 reset table", tbl_out, 16'h0000);
    check("R1 reset done", {15'b0, done}, 16'h0000);
    rst_n = 1'b1;

    // Hand-worked stride and direction cases
    run_job(16'h0001, 2, 0, cyc);
    check("R3 stride 4", tbl_out, 16'h0011);
    run_job(16'h0001, 1, 0, cyc);
    check("R3 stride 2", tbl_out, 16'h0005);
    run_job(16'h00FF, 3, 0, cyc);
    check("R4 pin3 stuck0", tbl_out, 16'hFFFF);
    run_job(16'hAAAA, 0, 0, cyc);
    check("R4 pin0 stuck0", tbl_out, 16'h0000);
    run_job(16'h00FF, 3, 1, cyc);
    check("R5 pin3 stuck1", tbl_out, 16'h0000);
    run_job(16'hAAAA, 0, 1, cyc);
    check("R5 pin0 stuck1", tbl_out, 16'hFFFF);
    check("R6 R7 done timing", 16'(cyc), 16'd9);

    // Idle hold
    held = tbl_out;
    tbl_in = 16'h5A5A;
    repeat (5) @(negedge clk);
    check("R10 idle hold", tbl_out, held);

    // Exhaustive sweep over pins and values
    t = 16'h8E69;
    for (int n = 0; n < 4; n++) begin
      for (int p = 0; p < 4; p++) begin
        for (int v = 0; v < 2; v++) begin
          run_job(t, p, v, cyc);
          check("R9 forced equivalence", tbl_out, forced(t, p, v));
          check("R7 done latency", 16'(cyc), 16'd9);
        end
      end
      t = {t[14:0], t[15] ^ t[13] ^ t[12] ^ t[10]} ^ 16'h1357;
    end

    // Start while busy is ignored
    @(negedge clk);
    tbl_in = 16'h00E8; pin_sel = 2'd1; stuck_val = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    tbl_in = 16'hFFFF; pin_sel = 2'd3; stuck_val = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    check("R8 busy start ignored", tbl_out, forced(16'h00E8, 1, 1));

    // Start during the done cycle is accepted
    tbl_in = 16'h1234; pin_sel = 2'd2; stuck_val = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8 start in done cycle accepted", tbl_out, 16'h1234);
    cyc = 0;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    check("R9 after back-to-back", tbl_out, forced(16'h1234, 2, 0));

    repeat (2) @(negedge clk);
    summary_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule